// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block collects the completion flags of fifteen DMA channels and presents them to a two-level interrupt controller that raises a single CPU interrupt. Each channel holds a level flag, which the channel keeps asserted until its completion has been serviced. The block captures these flags once per clock and shows them in a read-only per-channel status word.

The captured flags drive lines of a 32-bit peripheral pending bank. Channels 0 to 10 each own one line, at 16 plus the channel number. Channels 11 to 14 share line 27. The bank is masked by an enable word. Enables are set and cleared through separate write-one registers. A summary word carries one aggregate bit that stands for the whole bank, and the CPU interrupt is the OR of the summary word.

Software reaches every register through one address/data port. Reads are combinational on the address. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset the status word (0xFE0), the summary word (0x000), the bank pending word (0x004) and the enable word (0x010) all read 0, and `cpu_irq` is 0.
- R2: Bit n of the status word at 0xFE0 equals channel n's flag as sampled on the previous rising clock edge. Bits 15 to 31 read 0.
- R3: Channel n for n from 0 to 10 drives bank line 16+n, one line per channel. No other channel drives these lines.
- R4: Channels 11 to 14 are ORed onto bank line 27. That line stays raised as long as at least one of these four flags is set.
- R5: The bank pending word at 0x004 equals the raw line state ANDed with the enable word. With a line enabled and no flag set, it reads 0.
- R6: Bit 8 of the summary word at 0x000 is 1 exactly when the bank pending word is nonzero. All other summary bits read 0.
- R7: Writing to 0x010 sets each enable bit whose data bit is 1 and leaves the enable bits whose data bit is 0 unchanged. Reading 0x010 returns the enable word.
- R8: Writing to 0x01C clears each enable bit whose data bit is 1 and leaves the others unchanged.
- R9: `cpu_irq` is the OR of all summary word bits.
- R10: When a channel's flag drops, its status bit, its bank pending bit and the summary aggregate bit (if no other line is pending) return to 0 one cycle after the drop is sampled.
- R11: Reads of any address that is not mapped return 0. Writes to the status, summary and pending addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_flag | input | 15 | Completion flag level of each DMA channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data for `addr` |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The routing is exercised with single flags on the first dedicated channel, the last dedicated channel, and the first and last shared channels. These patterns separate the per-channel lines from the shared line and catch off-by-one line mapping. A flag paired with a mismatched enable shows that masking happens after routing. All flags set with all enables shows that no line outside 16 to 27 is ever raised. A two-flag release sequence on the shared channels shows that line 27 holds until the last contributor drops. Directed writes of zero bits to both enable registers, and writes to read-only addresses, show that those writes leave the state alone.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned REG_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_SUMMARY = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_PEND    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_EN_SET  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_CH_STAT = 12'hFE0;
endpackage

// File: rtl/dmairq_flag_capture.sv
module dmairq_flag_capture #(
  parameter int unsigned NUM_CH = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_flag,
  output logic [NUM_CH-1:0] flags_q
);
  logic [NUM_CH-1:0] flags_d;
  logic              past_ok;

  always_comb begin
    flags_d = chan_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      past_ok <= 1'b0;
    end else begin
      flags_q <= flags_d;
      past_ok <= 1'b1;
    end
  end

  // R2: the captured word trails the channel inputs by one edge
  p_status_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> flags_q == $past(chan_flag));
endmodule

// File: rtl/dmairq_line_map.sv
module dmairq_line_map #(
  parameter int unsigned NUM_CH        = 15,
  parameter int unsigned NUM_DEDICATED = 11,
  parameter int unsigned LINE_BASE     = 16,
  parameter int unsigned BANK_W        = 32
) (
  input  logic [NUM_CH-1:0] flags,
  output logic [BANK_W-1:0] lines
);
  localparam int unsigned SHARED_LINE = LINE_BASE + NUM_DEDICATED;
  localparam int unsigned NUM_SHARED  = NUM_CH - NUM_DEDICATED;

  logic [BANK_W-1:0] ded_lines;
  logic              shared_any;

  for (genvar i = 0; i < BANK_W; i++) begin : g_line
    if (i >= LINE_BASE && i < SHARED_LINE) begin : g_ded
      assign ded_lines[i] = flags[i-LINE_BASE];
    end else begin : g_none
      assign ded_lines[i] = 1'b0;
    end
  end

  if (NUM_SHARED > 0) begin : g_shared
    assign shared_any = |flags[NUM_CH-1:NUM_DEDICATED];
  end else begin : g_noshared
    assign shared_any = 1'b0;
  end

  always_comb begin
    lines = ded_lines;
    lines[SHARED_LINE] = shared_any;
  end
endmodule

// File: rtl/dmairq_bank_ctrl.sv
module dmairq_bank_ctrl #(
  parameter int unsigned BANK_W  = 32,
  parameter int unsigned AGG_BIT = 8,
  parameter int unsigned SUM_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] lines,
  output logic [BANK_W-1:0] enable_q,
  output logic [BANK_W-1:0] pend,
  output logic [SUM_W-1:0]  summary,
  output logic              cpu_irq
);
  logic [BANK_W-1:0] enable_d;
  logic              en_ce;
  logic              past_ok;

  always_comb begin
    en_ce    = set_we | clr_we;
    enable_d = enable_q;
    if (set_we) enable_d = enable_d | wdata;
    if (clr_we) enable_d = enable_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      past_ok  <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (en_ce) enable_q <= enable_d;
    end
  end

  always_comb begin
    pend             = lines & enable_q;
    summary          = '0;
    summary[AGG_BIT] = |pend;
    cpu_irq          = |summary;
  end

  // R7: bits written to the set register are enabled afterwards
  p_enable_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(set_we) && !$past(clr_we)) |-> ((enable_q & $past(wdata)) == $past(wdata)));
  // R8: bits written to the clear register are disabled afterwards
  p_enable_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(clr_we)) |-> ((enable_q & $past(wdata)) == '0));
  // R7/R8: without a write strobe the enable word holds
  p_enable_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(set_we) && !$past(clr_we)) |-> $stable(enable_q));
  // R5: nothing outside the enable word is ever pending
  p_pend_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~enable_q) == '0);
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH        = 15,
  parameter int unsigned NUM_DEDICATED = 11,
  parameter int unsigned LINE_BASE     = 16,
  parameter int unsigned BANK_W        = 32,
  parameter int unsigned AGG_BIT       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_flag,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              cpu_irq
);
  localparam int unsigned SHARED_LINE = LINE_BASE + NUM_DEDICATED;

  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic [NUM_CH-1:0] stat_q;
  logic [BANK_W-1:0] raw_lines;
  logic [BANK_W-1:0] enable_q;
  logic [BANK_W-1:0] pend;
  logic [REG_W-1:0]  summary;
  logic              set_we;
  logic              clr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  dmairq_flag_capture #(.NUM_CH(NUM_CH)) u_cap (
    .clk(clk), .rst_n(rst_q_n), .chan_flag(chan_flag), .flags_q(stat_q)
  );

  dmairq_line_map #(
    .NUM_CH(NUM_CH), .NUM_DEDICATED(NUM_DEDICATED),
    .LINE_BASE(LINE_BASE), .BANK_W(BANK_W)
  ) u_map (
    .flags(stat_q), .lines(raw_lines)
  );

  always_comb begin
    set_we = wr_en && (addr == OFS_EN_SET);
    clr_we = wr_en && (addr == OFS_EN_CLR);
  end

  dmairq_bank_ctrl #(
    .BANK_W(BANK_W), .AGG_BIT(AGG_BIT), .SUM_W(REG_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_q_n), .set_we(set_we), .clr_we(clr_we),
    .wdata(wr_data[BANK_W-1:0]), .lines(raw_lines), .enable_q(enable_q),
    .pend(pend), .summary(summary), .cpu_irq(cpu_irq)
  );

  always_comb begin
    rd_data = '0;
    case (addr)
      OFS_SUMMARY: rd_data = summary;
      OFS_PEND:    rd_data = REG_W'(pend);
      OFS_EN_SET:  rd_data = REG_W'(enable_q);
      OFS_CH_STAT: rd_data = REG_W'(stat_q);
      default:     rd_data = '0;
    endcase
  end

  // R4: the shared line follows the captured flags of the shared channels
  p_shared_line_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    raw_lines[SHARED_LINE] == (stat_q[NUM_CH-1:NUM_DEDICATED] != '0));
  // R10: with no channel flag captured, the CPU request is low
  p_quiet_when_clear_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stat_q == '0) |-> !cpu_irq);
  // R9: the CPU request tracks the aggregate summary bit
  p_irq_matches_sum_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    cpu_irq == summary[AGG_BIT]);
endmodule

// File: tb/sim_dma_irq_aggregator.sv
module sim_dma_irq_aggregator;
  localparam int PERIOD = 10;
  localparam int NV = 8;

  localparam logic [14:0] V_FLAGS [NV] = '{15'h0001, 15'h0400, 15'h0800, 15'h4000,
                                          15'h0001, 15'h0000, 15'h7FFF, 15'h0022};
  localparam logic [31:0] V_EN    [NV] = '{32'h0001_0000, 32'h0400_0000, 32'h0800_0000,
                                          32'h0800_0000, 32'h0002_0000, 32'hFFFF_FFFF,
                                          32'hFFFF_FFFF, 32'h0020_0000};
  localparam logic [31:0] V_PEND  [NV] = '{32'h0001_0000, 32'h0400_0000, 32'h0800_0000,
                                          32'h0800_0000, 32'h0000_0000, 32'h0000_0000,
                                          32'h0FFF_0000, 32'h0020_0000};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] chan_flag;
  logic        wr_en;
  logic [11:0] addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        cpu_irq;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .chan_flag(chan_flag), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic flags(input logic [14:0] f);
    @(negedge clk);
    chan_flag = f;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_all(input string tag, input logic [14:0] f, input logic [31:0] p);
    logic [31:0] d;
    logic [31:0] s;
    s = (p != 0) ? 32'h0000_0100 : 32'h0;
    rd(12'hFE0, d); chk({tag, " R2 status"}, d, {17'h0, f});
    rd(12'h004, d); chk({tag, " R5 pending"}, d, p);
    rd(12'h000, d); chk({tag, " R6 summary"}, d, s);
    chk({tag, " R9 cpu_irq"}, {31'h0, cpu_irq}, {31'h0, s != 0});
  endtask

  initial begin
    #(PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; chan_flag = '0; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1: reset state
    chk_all("R1 reset", 15'h0, 32'h0);
    rd(12'h010, d); chk("R1 enable", d, 32'h0);

    // Vector table: R3 R4 R5 R6 R9 routing and masking
    for (int i = 0; i < NV; i++) begin
      wr(12'h01C, 32'hFFFF_FFFF);
      wr(12'h010, V_EN[i]);
      flags(V_FLAGS[i]);
      chk_all($sformatf("R3/R4 vec%0d", i), V_FLAGS[i], V_PEND[i]);
      flags(15'h0);
      chk_all($sformatf("R10 vec%0d cleared", i), 15'h0, 32'h0);
    end

    // R7: zero bits leave enables unchanged, ones add
    wr(12'h01C, 32'hFFFF_FFFF);
    wr(12'h010, 32'h0001_0000);
    wr(12'h010, 32'h0000_0000);
    rd(12'h010, d); chk("R7 zero write keeps", d, 32'h0001_0000);
    wr(12'h010, 32'h0800_0000);
    rd(12'h010, d); chk("R7 set accumulates", d, 32'h0801_0000);

    // R8: clear register removes only the written ones
    wr(12'h01C, 32'h0001_0000);
    rd(12'h010, d); chk("R8 clear one bit", d, 32'h0800_0000);
    wr(12'h01C, 32'h0000_0000);
    rd(12'h010, d); chk("R8 zero write keeps", d, 32'h0800_0000);

    // R4: shared line held until the last shared flag drops
    flags(15'h2800);
    chk_all("R4 ch11+ch13", 15'h2800, 32'h0800_0000);
    flags(15'h2000);
    chk_all("R4 ch13 remains", 15'h2000, 32'h0800_0000);
    flags(15'h0000);
    chk_all("R10 shared released", 15'h0, 32'h0);

    // R11: unmapped reads, writes to read-only addresses
    flags(15'h0001);
    rd(12'h008, d); chk("R11 unmapped 0x008", d, 32'h0);
    rd(12'hFE4, d); chk("R11 unmapped 0xFE4", d, 32'h0);
    wr(12'hFE0, 32'h0000_0000);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h000, 32'h0000_0000);
    rd(12'hFE0, d); chk("R11 status unchanged", d, 32'h0000_0001);
    rd(12'h010, d); chk("R11 enable unchanged", d, 32'h0800_0000);
    chk_all("R11 after ro writes", 15'h0001, 32'h0);

    // R10: clearing the flag on an enabled line drops everything
    wr(12'h010, 32'h0001_0000);
    chk_all("R10 enabled set", 15'h0001, 32'h0001_0000);
    flags(15'h0000);
    chk_all("R10 enabled cleared", 15'h0, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule